// File: doc/BRIEF.md
# Vectored Interrupt Dispatch Unit

The block gathers level-sensitive interrupt lines from peripherals and turns them into one vectored interrupt towards the core. It has up to 48 vector lines. It also has 16 legacy bus interrupt lines, which pass through a fixed translation table that maps a few legacy numbers onto vector numbers. A legacy line with no table entry is dropped.

The unit holds one interrupt at a time. The first rising line it sees while idle sets the busy flag, asserts the hard request, gives a one-cycle wake pulse and loads a three-word payload that names the vector. Every other rise is ignored until the captured line goes low. That low level releases the unit. Edges are found by comparing each sampled line set with a registered copy from the cycle before.

Top module: `vid_dispatch`

## Requirements
- R1: After reset, busy, irq_req and wake are low and data0, data1 and data2 are zero.
- R2: When the unit is idle and a line rises, busy and irq_req are high after the next clock edge. wake is high for exactly that one cycle.
- R3: On a capture, data0 becomes (0x1f << 6) | vector, which puts the value 0x1f in bits 10..6 and the vector in bits 5..0. data1 and data2 become zero.
- R4: A line that rises while busy is high is ignored: busy stays high and data0 keeps its value.
- R5: When the captured line goes low, busy and irq_req drop after the next clock edge. data0 keeps the last payload.
- R6: While busy is high, a line other than the captured one going low has no effect.
- R7: When several lines rise in the same cycle, the lowest-numbered vector is captured.
- R8: Legacy lines 1, 4, 6, 7 and 12 map to vectors 0x29, 0x2b, 0x27, 0x22 and 0x2a. Every other legacy line has no effect. A mapped legacy line is ORed with the vector line of the same number.
- R9: A line that is still high when busy drops does not cause a new capture. Only a new rising edge does.
- R10: If the captured line goes low in the same cycle that another line rises, the unit goes idle and does not capture the rising line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| vec_lines | input | NUM_VEC (48) | Vector interrupt levels, bit n is vector n |
| legacy_lines | input | NUM_LEGACY (16) | Legacy bus interrupt levels |
| busy | output | 1 | An interrupt is held |
| irq_req | output | 1 | Hard interrupt request to the core |
| wake | output | 1 | One-cycle pulse on capture, clears the core's halt state |
| data0 | output | DATA_W (64) | Payload word 0 |
| data1 | output | DATA_W (64) | Payload word 1 (zero) |
| data2 | output | DATA_W (64) | Payload word 2 (zero) |

## Verification
Two events can fall in the same cycle: the captured line being released, and a new line rising. The bench drops vector 10 while it raises vector 11 in one step. It expects busy low with no wake pulse. It then holds vector 11 high for a further cycle and expects that no capture follows. A second collision happens on capture itself. Several legacy lines map to different vectors, and they rise together. The bench judges this case by the vector in data0, which must be the lowest one.

// File: rtl/vid_pkg.sv
package vid_pkg;

  // Legacy route: bit 6 = valid, bits 5..0 = vector number
  function automatic logic [6:0] legacy_route(input int idx);
    case (idx)
      1:       legacy_route = {1'b1, 6'h29};
      4:       legacy_route = {1'b1, 6'h2b};
      6:       legacy_route = {1'b1, 6'h27};
      7:       legacy_route = {1'b1, 6'h22};
      12:      legacy_route = {1'b1, 6'h2a};
      default: legacy_route = 7'h00;
    endcase
  endfunction

  // Payload word 0: fixed 0x1f field above the vector number
  function automatic logic [63:0] payload_word(input logic [5:0] vec);
    payload_word = (64'h1f << 6) | {58'd0, vec};
  endfunction

endpackage

// File: rtl/vid_legacy_map.sv
module vid_legacy_map #(
  parameter int NUM_LEGACY = 16,
  parameter int NUM_VEC    = 48
) (
  input  logic [NUM_LEGACY-1:0] legacy_lines,
  output logic [NUM_VEC-1:0]    mapped
);
  import vid_pkg::*;

  always_comb begin
    mapped = '0;
    for (int i = 0; i < NUM_LEGACY; i++) begin
      logic [6:0] r;
      r = legacy_route(i);
      if (r[6] && (int'(r[5:0]) < NUM_VEC))
        mapped[r[5:0]] = mapped[r[5:0]] | legacy_lines[i];
    end
  end
endmodule

// File: rtl/vid_edge_detect.sv
module vid_edge_detect #(
  parameter int NUM_VEC = 48
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_VEC-1:0] lines,
  output logic [NUM_VEC-1:0] rise,
  output logic [NUM_VEC-1:0] fall
);
  logic [NUM_VEC-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= lines;
  end

  assign rise = lines & ~prev_q;
  assign fall = ~lines & prev_q;
endmodule

// File: rtl/vid_prio_pick.sv
module vid_prio_pick #(
  parameter int NUM_VEC = 48,
  localparam int VEC_W  = $clog2(NUM_VEC)
) (
  input  logic [NUM_VEC-1:0] req,
  output logic               found,
  output logic [VEC_W-1:0]   idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = NUM_VEC - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = VEC_W'(i);
      end
    end
  end
endmodule

// File: rtl/vid_dispatch.sv
module vid_dispatch #(
  parameter int NUM_VEC    = 48,
  parameter int NUM_LEGACY = 16,
  parameter int DATA_W     = 64
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_VEC-1:0]    vec_lines,
  input  logic [NUM_LEGACY-1:0] legacy_lines,
  output logic                  busy,
  output logic                  irq_req,
  output logic                  wake,
  output logic [DATA_W-1:0]     data0,
  output logic [DATA_W-1:0]     data1,
  output logic [DATA_W-1:0]     data2
);
  import vid_pkg::*;

  localparam int VEC_W = $clog2(NUM_VEC);
  localparam logic [NUM_VEC-1:0] ONE = {{(NUM_VEC-1){1'b0}}, 1'b1};

  logic [NUM_VEC-1:0] legacy_vec, all_lines, rise_vec, fall_vec;
  logic               any_rise;
  logic [VEC_W-1:0]   pick_idx;
  logic               capture_evt, release_evt;

  logic               busy_q, wake_q;
  logic [VEC_W-1:0]   cap_q;
  logic [DATA_W-1:0]  d0_q, d1_q, d2_q;

  vid_legacy_map #(.NUM_LEGACY(NUM_LEGACY), .NUM_VEC(NUM_VEC)) u_map (
    .legacy_lines(legacy_lines),
    .mapped      (legacy_vec)
  );

  assign all_lines = vec_lines | legacy_vec;

  vid_edge_detect #(.NUM_VEC(NUM_VEC)) u_edge (
    .clk  (clk),
    .rst_n(rst_n),
    .lines(all_lines),
    .rise (rise_vec),
    .fall (fall_vec)
  );

  vid_prio_pick #(.NUM_VEC(NUM_VEC)) u_pick (
    .req  (rise_vec),
    .found(any_rise),
    .idx  (pick_idx)
  );

  assign capture_evt = !busy_q && any_rise;
  assign release_evt = busy_q && fall_vec[cap_q];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      wake_q <= 1'b0;
      cap_q  <= '0;
      d0_q   <= '0;
      d1_q   <= '0;
      d2_q   <= '0;
    end else begin
      wake_q <= capture_evt;
      if (capture_evt) begin
        busy_q <= 1'b1;
        cap_q  <= pick_idx;
        d0_q   <= DATA_W'(payload_word(6'(pick_idx)));
        d1_q   <= '0;
        d2_q   <= '0;
      end else if (release_evt) begin
        busy_q <= 1'b0;
      end
    end
  end

  assign busy    = busy_q;
  assign irq_req = busy_q;
  assign wake    = wake_q;
  assign data0   = d0_q;
  assign data1   = d1_q;
  assign data2   = d2_q;

  // Assertions
  p_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
    capture_evt |=> busy && irq_req && wake);

  p_wake_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wake |=> !wake);

  p_payload_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> (data0[10:6] == 5'h1f) && (data1 == '0) && (data2 == '0));

  p_ignore_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !release_evt) |=> busy && $stable(data0));

  p_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    release_evt |=> !busy && !irq_req && !wake);

  p_prio_r7: assert property (@(posedge clk) disable iff (!rst_n)
    any_rise |-> rise_vec[pick_idx] && ((rise_vec & ((ONE << pick_idx) - ONE)) == '0));
endmodule

// File: tb/vid_dispatch_test.sv
`timescale 1ns/1ps
module vid_dispatch_test;
  localparam int NV = 48;
  localparam int NL = 16;

  typedef struct {
    bit          busy;
    bit          wake;
    logic [63:0] d0;
    string       tag;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NV-1:0] vec_lines = '0;
  logic [NL-1:0] legacy_lines = '0;
  logic          busy, irq_req, wake;
  logic [63:0]   data0, data1, data2;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  exp_t q[$];

  always #2.5 clk = ~clk;

  vid_dispatch uut (
    .clk(clk), .rst_n(rst_n), .vec_lines(vec_lines), .legacy_lines(legacy_lines),
    .busy(busy), .irq_req(irq_req), .wake(wake),
    .data0(data0), .data1(data1), .data2(data2)
  );

  function automatic logic [63:0] pay(input int v);
    return 64'd1984 + 64'(v);   // 0x7c0 + vector
  endfunction

  task automatic apply(input logic [NV-1:0] v, input logic [NL-1:0] l,
                       input bit eb, input bit ew, input logic [63:0] ed, input string tag);
    exp_t e;
    @(negedge clk);
    vec_lines = v;
    legacy_lines = l;
    e.busy = eb; e.wake = ew; e.d0 = ed; e.tag = tag;
    q.push_back(e);
  endtask

  // Monitor
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (busy !== e.busy || irq_req !== e.busy || wake !== e.wake || data0 !== e.d0 ||
          data1 !== 64'd0 || data2 !== 64'd0) begin
        errors++;
        $display("FAIL %s: busy=%b irq=%b wake=%b d0=%h d1=%h d2=%h expected busy=%b irq=%b wake=%b d0=%h d1=0 d2=0",
                 e.tag, busy, irq_req, wake, data0, data1, data2, e.busy, e.busy, e.wake, e.d0);
      end
    end
  end

  // Watchdog
  initial begin
    #100000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    checks++;
    if (busy !== 0 || irq_req !== 0 || wake !== 0 || data0 !== 0 || data1 !== 0 || data2 !== 0) begin
      errors++;
      $display("FAIL R1: busy=%b irq=%b wake=%b d0=%h d1=%h d2=%h expected all zero",
               busy, irq_req, wake, data0, data1, data2);
    end

    apply(48'h20, '0, 1, 1, pay(5), "R2 R3 capture of vector 5");
    apply(48'h20, '0, 1, 0, pay(5), "R2 wake lasts one cycle");
    apply(48'h220, '0, 1, 0, pay(5), "R4 rise while busy ignored");
    apply(48'h20, '0, 1, 0, pay(5), "R6 other line falls, no effect");
    apply(48'h0, '0, 0, 0, pay(5), "R5 captured line falls");
    apply((48'h1 << 3) | (48'h1 << 40), '0, 1, 1, pay(3), "R7 lowest of 3 and 40");
    apply(48'h1 << 40, '0, 0, 0, pay(3), "R5 release of vector 3");
    apply(48'h1 << 40, '0, 0, 0, pay(3), "R9 held line no retrigger");
    apply(48'h0, '0, 0, 0, pay(3), "R9 idle");
    apply(48'h0, 16'h0002, 1, 1, pay(8'h29), "R8 legacy 1 to 0x29");
    apply(48'h0, 16'h0000, 0, 0, pay(8'h29), "R8 legacy release");
    apply(48'h0, 16'h0004, 0, 0, pay(8'h29), "R8 unmapped legacy 2 dropped");
    apply(48'h0, 16'h0000, 0, 0, pay(8'h29), "R8 idle");
    apply(48'h0, 16'h10d0, 1, 1, pay(8'h22), "R8 R7 legacy 4,6,7,12 pick 0x22");
    apply(48'h0, 16'h0000, 0, 0, pay(8'h22), "R5 legacy group release");
    apply(48'h1 << 10, '0, 1, 1, pay(10), "R2 capture vector 10");
    apply(48'h1 << 11, '0, 0, 0, pay(10), "R10 release and rise same cycle");
    apply(48'h1 << 11, '0, 0, 0, pay(10), "R10 missed rise not captured");
    apply(48'h0, '0, 0, 0, pay(10), "R10 idle");
    apply(48'h0, 16'h1000, 1, 1, pay(8'h2a), "R8 legacy 12 to 0x2a");
    apply(48'h0, 16'h0000, 0, 0, pay(8'h2a), "R5 legacy 12 release");
    apply(48'h1 << 47, '0, 1, 1, pay(47), "R3 top vector 47");
    apply(48'h0, '0, 0, 0, pay(47), "R5 vector 47 release");

    repeat (4) @(posedge clk);
    #2;
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule